// File: doc/BRIEF.md
# Full-Duplex PAUSE Flow Controller

This block sits between a host and the transmit and receive byte paths of a full-duplex Ethernet MAC. On the receive side it forwards each received byte to the host one cycle later. It recognises MAC control frames while they stream past. When a control frame ends it either marks the frame for dropping or lets it through, as a configuration bit selects. When the frame is a PAUSE request, its 16-bit quanta value is loaded into a hold counter. A free-running slot timer decrements that counter once per slot time. The block raises a transmit-inhibit output while the counter is non-zero, so the host does not open a new frame.

On the transmit side, host bytes normally pass straight to the MAC. A one-cycle request from the host queues a locally built PAUSE frame. The block inserts that frame as soon as no host frame is open, and it holds the inhibit output high until the inserted frame is complete. A host frame that is already open is never cut.

Top module: `pause_flow_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_inhibit`, `host_rx_valid` and `tx_valid` are 0.
- R2: Every received byte with `rx_valid` high appears on the `host_rx_*` outputs one cycle later with identical data, `sof` and `eof`.
- R3: A frame counts as a control frame under three conditions. Bytes 0..5 (index 0 = first byte after the start marker, address most significant byte first) equal 01-80-C2-00-00-01 or `cfg_station_addr`. Bytes 12..13 equal 0x88, 0x08. Its last byte has index 18 or more. On such a frame `host_rx_drop` is 1 together with `host_rx_eof` when `cfg_pass_ctrl` is 0, and 0 when it is 1. Any other frame is never marked.
- R4: A control frame whose bytes 14..15 equal 0x00, 0x01 is a PAUSE frame. Its bytes 16..17 (high byte first) load the hold counter on the clock edge after the one that presents `host_rx_eof`, whatever `cfg_pass_ctrl` is. A control frame with any other opcode loads nothing. `tx_inhibit` is high while the counter is non-zero.
- R5: The slot timer ticks once every `SLOT_CYCLES` clock cycles. Each tick lowers a non-zero counter by one, and a load takes priority over a tick. After a load of Q > 0, `tx_inhibit` is still high after (Q-1)*`SLOT_CYCLES` edges and low after Q*`SLOT_CYCLES` edges.
- R6: A PAUSE frame carrying quanta 0 clears a running hold at its load edge.
- R7: A PAUSE frame received during a hold restarts the counter from its own value.
- R8: A `pause_req` pulse makes `tx_inhibit` high from the next edge. It also emits on `tx_*` a 60-byte frame: group address 01-80-C2-00-00-01, `cfg_station_addr`, 0x88 0x08, 0x00 0x01, `cfg_pause_quanta` high byte first, then zero bytes. `tx_sof` is set on its first byte and `tx_eof` on its last.
- R9: When no generated frame is being sent, host bytes, `sof` and `eof` pass unchanged to `tx_*` in the same cycle. A host frame that is open when a hold starts continues to its end.
- R10: A `pause_req` made during an open host frame inserts the generated frame only after that host frame's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pass_ctrl | input | 1 | 1: pass control frames to host; 0: mark them for dropping |
| cfg_station_addr | input | 48 | Own station address |
| cfg_pause_quanta | input | 16 | Quanta placed in generated PAUSE frames |
| pause_req | input | 1 | One-cycle request to send a PAUSE frame |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a received frame |
| rx_eof | input | 1 | Last byte of a received frame |
| host_rx_valid | output | 1 | Byte valid toward host |
| host_rx_data | output | 8 | Byte toward host |
| host_rx_sof | output | 1 | First byte toward host |
| host_rx_eof | output | 1 | Last byte toward host |
| host_rx_drop | output | 1 | With eof: host discards this control frame |
| host_tx_valid | input | 1 | Host transmit byte valid |
| host_tx_data | input | 8 | Host transmit byte |
| host_tx_sof | input | 1 | Host first byte |
| host_tx_eof | input | 1 | Host last byte |
| tx_inhibit | output | 1 | Host must not open a new frame |
| tx_valid | output | 1 | Byte valid toward transmit MAC |
| tx_data | output | 8 | Byte toward transmit MAC |
| tx_sof | output | 1 | First byte toward transmit MAC |
| tx_eof | output | 1 | Last byte toward transmit MAC |

## Verification
On every cycle the assertions check several local rules. The hold counter loads, steps down by exactly one per tick, and stays still otherwise. Drop and load marks only come with an end-of-frame byte. Slot ticks never come back to back. An inserted frame begins at its first byte, ends after its sixtieth, and never begins while a host frame is open. Other properties need the bench's scenarios: which headers count as control frames, the effect of the pass bit, the hold length in slots against a free-running tick phase, reload and clear by later frames, and the byte-exact content and ordering of the merged transmit stream.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int MAC_W    = 48;
  localparam int QUANTA_W = 16;
  localparam int GEN_LEN  = 60;
  localparam int GIDX_W   = $clog2(GEN_LEN);
  localparam int HDR_END  = 18;
  localparam int RIDX_W   = $clog2(HDR_END + 1) + 1;
  localparam logic [15:0] CTRL_ETYPE  = 16'h8808;
  localparam logic [15:0] OP_PAUSE    = 16'h0001;
  localparam logic [47:0] PAUSE_GROUP = 48'h0180_C200_0001;

  // octet k (0 = first on the wire) of a 48-bit address
  function automatic logic [7:0] mac_octet(input logic [47:0] a, input int unsigned k);
    return a[8*(5-k) +: 8];
  endfunction

  // octet i of the locally built PAUSE frame
  function automatic logic [7:0] pause_octet(input int unsigned i, input logic [47:0] sa,
                                             input logic [15:0] q);
    if (i < 6)        return mac_octet(PAUSE_GROUP, i);
    else if (i < 12)  return mac_octet(sa, i - 6);
    else if (i == 12) return CTRL_ETYPE[15:8];
    else if (i == 13) return CTRL_ETYPE[7:0];
    else if (i == 14) return OP_PAUSE[15:8];
    else if (i == 15) return OP_PAUSE[7:0];
    else if (i == 16) return q[15:8];
    else if (i == 17) return q[7:0];
    return 8'h00;
  endfunction
endpackage

// File: rtl/fc_slot_timer.sv
module fc_slot_timer #(
  parameter int SLOT_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_tick
);
  localparam int CW = $clog2(SLOT_CYCLES);
  localparam logic [CW-1:0] TOP = CW'(SLOT_CYCLES - 1);
  logic [CW-1:0] cnt_q;

  assign slot_tick = (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (slot_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> !slot_tick);
endmodule

// File: rtl/fc_rx_detect.sv
module fc_rx_detect
  import fc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_pass_ctrl,
  input  logic [MAC_W-1:0]    station_addr,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                rx_sof,
  input  logic                rx_eof,
  output logic                host_rx_valid,
  output logic [7:0]          host_rx_data,
  output logic                host_rx_sof,
  output logic                host_rx_eof,
  output logic                host_rx_drop,
  output logic                pause_hit,
  output logic [QUANTA_W-1:0] pause_val
);
  localparam logic [RIDX_W-1:0] I_ADDR_END = RIDX_W'(6);
  localparam logic [RIDX_W-1:0] I_TYPE_HI  = RIDX_W'(12);
  localparam logic [RIDX_W-1:0] I_TYPE_LO  = RIDX_W'(13);
  localparam logic [RIDX_W-1:0] I_OP_HI    = RIDX_W'(14);
  localparam logic [RIDX_W-1:0] I_OP_LO    = RIDX_W'(15);
  localparam logic [RIDX_W-1:0] I_Q_HI     = RIDX_W'(16);
  localparam logic [RIDX_W-1:0] I_Q_LO     = RIDX_W'(17);
  localparam logic [RIDX_W-1:0] I_HDR_END  = RIDX_W'(HDR_END);
  localparam logic [RIDX_W-1:0] I_SAT      = '1;

  logic [RIDX_W-1:0]   idx_q, cur;
  logic                grp_q, own_q, ety_q, op_q;
  logic                grp_n, own_n, ety_n, op_n;
  logic [QUANTA_W-1:0] val_q;
  logic                ctrl_end, pause_end;

  always_comb begin
    cur   = rx_sof ? '0 : idx_q;
    grp_n = (cur == '0) ? 1'b1 : grp_q;
    own_n = (cur == '0) ? 1'b1 : own_q;
    if (cur < I_ADDR_END) begin
      grp_n = grp_n & (rx_data == mac_octet(PAUSE_GROUP, 32'(cur)));
      own_n = own_n & (rx_data == mac_octet(station_addr, 32'(cur)));
    end
    ety_n = ety_q;
    if (cur == I_TYPE_HI) ety_n = (rx_data == CTRL_ETYPE[15:8]);
    if (cur == I_TYPE_LO) ety_n = ety_q & (rx_data == CTRL_ETYPE[7:0]);
    op_n = op_q;
    if (cur == I_OP_HI) op_n = (rx_data == OP_PAUSE[15:8]);
    if (cur == I_OP_LO) op_n = op_q & (rx_data == OP_PAUSE[7:0]);
    ctrl_end  = rx_valid & rx_eof & (cur >= I_HDR_END) & (grp_q | own_q) & ety_q;
    pause_end = ctrl_end & op_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; grp_q <= 1'b0; own_q <= 1'b0; ety_q <= 1'b0; op_q <= 1'b0;
      val_q <= '0;
      host_rx_valid <= 1'b0; host_rx_data <= '0; host_rx_sof <= 1'b0;
      host_rx_eof <= 1'b0; host_rx_drop <= 1'b0; pause_hit <= 1'b0; pause_val <= '0;
    end else begin
      if (rx_valid) begin
        idx_q <= (cur == I_SAT) ? cur : cur + 1'b1;
        grp_q <= grp_n; own_q <= own_n; ety_q <= ety_n; op_q <= op_n;
        if (cur == I_Q_HI) val_q[15:8] <= rx_data;
        if (cur == I_Q_LO) val_q[7:0]  <= rx_data;
      end
      host_rx_valid <= rx_valid;
      host_rx_data  <= rx_data;
      host_rx_sof   <= rx_valid & rx_sof;
      host_rx_eof   <= rx_valid & rx_eof;
      host_rx_drop  <= ctrl_end & ~cfg_pass_ctrl;
      pause_hit     <= pause_end;
      if (pause_end) pause_val <= val_q;
    end
  end

  // R3
  drop_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rx_drop |-> (host_rx_valid && host_rx_eof));
  // R4
  hit_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_hit |-> host_rx_eof);
  // R2
  fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (host_rx_valid && host_rx_data == $past(rx_data)));
endmodule

// File: rtl/fc_pause_timer.sv
module fc_pause_timer
  import fc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [QUANTA_W-1:0] load_val,
  input  logic                tick,
  output logic                hold
);
  logic [QUANTA_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign hold = (cnt_q != '0);

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  // R5
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && hold) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R5
  still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/fc_tx_insert.sv
module fc_tx_insert
  import fc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAC_W-1:0]    station_addr,
  input  logic [QUANTA_W-1:0] quanta,
  input  logic                pause_req,
  input  logic                host_tx_valid,
  input  logic [7:0]          host_tx_data,
  input  logic                host_tx_sof,
  input  logic                host_tx_eof,
  output logic                gen_busy,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_sof,
  output logic                tx_eof
);
  localparam logic [GIDX_W-1:0] LAST = GIDX_W'(GEN_LEN - 1);

  logic              pend_q, gen_q, host_busy_q, gen_start;
  logic [GIDX_W-1:0] gidx_q;

  assign gen_start = pend_q & ~gen_q & ~host_busy_q & ~(host_tx_valid & host_tx_sof);
  assign gen_busy  = pend_q | gen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0; gen_q <= 1'b0; gidx_q <= '0; host_busy_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~gen_start) | pause_req;
      if (host_tx_valid && host_tx_eof)      host_busy_q <= 1'b0;
      else if (host_tx_valid && host_tx_sof) host_busy_q <= 1'b1;
      if (gen_start) begin
        gen_q <= 1'b1; gidx_q <= '0;
      end else if (gen_q) begin
        if (gidx_q == LAST) gen_q <= 1'b0;
        else                gidx_q <= gidx_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (gen_q) begin
      tx_valid = 1'b1;
      tx_data  = pause_octet(32'(gidx_q), station_addr, quanta);
      tx_sof   = (gidx_q == '0);
      tx_eof   = (gidx_q == LAST);
    end else begin
      tx_valid = host_tx_valid;
      tx_data  = host_tx_data;
      tx_sof   = host_tx_sof;
      tx_eof   = host_tx_eof;
    end
  end

  // R8
  gen_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && gidx_q == LAST) |=> !gen_q);
  // R8
  gen_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_q) |-> gidx_q == '0);
  // R10
  gen_after_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_q) |-> !$past(host_busy_q));
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import fc_pkg::*;
#(
  parameter int SLOT_CYCLES = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_pass_ctrl,
  input  logic [MAC_W-1:0]    cfg_station_addr,
  input  logic [QUANTA_W-1:0] cfg_pause_quanta,
  input  logic                pause_req,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                rx_sof,
  input  logic                rx_eof,
  output logic                host_rx_valid,
  output logic [7:0]          host_rx_data,
  output logic                host_rx_sof,
  output logic                host_rx_eof,
  output logic                host_rx_drop,
  input  logic                host_tx_valid,
  input  logic [7:0]          host_tx_data,
  input  logic                host_tx_sof,
  input  logic                host_tx_eof,
  output logic                tx_inhibit,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_sof,
  output logic                tx_eof
);
  logic                slot_tick, pause_hit, hold, gen_busy;
  logic [QUANTA_W-1:0] pause_val;

  fc_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_slot (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick));

  fc_rx_detect u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_pass_ctrl(cfg_pass_ctrl),
    .station_addr(cfg_station_addr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .host_rx_valid(host_rx_valid),
    .host_rx_data(host_rx_data), .host_rx_sof(host_rx_sof), .host_rx_eof(host_rx_eof),
    .host_rx_drop(host_rx_drop), .pause_hit(pause_hit), .pause_val(pause_val));

  fc_pause_timer u_hold (
    .clk(clk), .rst_n(rst_n), .load(pause_hit), .load_val(pause_val),
    .tick(slot_tick), .hold(hold));

  fc_tx_insert u_tx (
    .clk(clk), .rst_n(rst_n), .station_addr(cfg_station_addr), .quanta(cfg_pause_quanta),
    .pause_req(pause_req), .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data),
    .host_tx_sof(host_tx_sof), .host_tx_eof(host_tx_eof), .gen_busy(gen_busy),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof));

  assign tx_inhibit = hold | gen_busy;

  // R4
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_hit && pause_val != '0 |=> tx_inhibit);
endmodule

// File: tb/sim_pause_flow_ctrl.sv
module sim_pause_flow_ctrl;
  localparam int S = 8;
  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] GRP = 48'h01_80_C2_00_00_01;
  localparam logic [15:0] GQ  = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_pass_ctrl = 1'b0, pause_req = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic host_tx_valid = 1'b0, host_tx_sof = 1'b0, host_tx_eof = 1'b0;
  logic [7:0] host_tx_data = '0;
  logic host_rx_valid, host_rx_sof, host_rx_eof, host_rx_drop;
  logic [7:0] host_rx_data, tx_data;
  logic tx_inhibit, tx_valid, tx_sof, tx_eof;

  int total = 0, bad = 0;
  logic [10:0] exp_rx[$];
  logic [9:0]  exp_tx[$];

  always #4 clk = ~clk;

  pause_flow_ctrl #(.SLOT_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pass_ctrl(cfg_pass_ctrl), .cfg_station_addr(STA),
    .cfg_pause_quanta(GQ), .pause_req(pause_req), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .host_rx_valid(host_rx_valid),
    .host_rx_data(host_rx_data), .host_rx_sof(host_rx_sof), .host_rx_eof(host_rx_eof),
    .host_rx_drop(host_rx_drop), .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data),
    .host_tx_sof(host_tx_sof), .host_tx_eof(host_tx_eof), .tx_inhibit(tx_inhibit),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof));

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_byte(int i, logic [47:0] da, logic [15:0] ty,
                                         logic [15:0] op, logic [15:0] pv);
    logic [111:0] hdr;
    hdr = {da, 48'hA6_A7_A8_A9_AA_AB, ty};
    if (i < 14) return 8'(hdr >> (8 * (13 - i)));
    if (i < 16) return 8'(op >> (8 * (15 - i)));
    if (i < 18) return 8'(pv >> (8 * (17 - i)));
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [7:0] gen_byte(int i);
    logic [143:0] hdr;
    hdr = {GRP, STA, 16'h8808, 16'h0001, GQ};
    if (i < 18) return 8'(hdr >> (8 * (17 - i)));
    return 8'h00;
  endfunction

  // driver: pushes expected host-side items, then drives the frame
  task automatic send_rx(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                         input logic [15:0] pv, input int len, input logic drop);
    for (int i = 0; i < len; i++)
      exp_rx.push_back({i == 0, i == len - 1, drop && (i == len - 1), rx_byte(i, da, ty, op, pv)});
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = rx_byte(i, da, ty, op, pv);
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic push_gen();
    for (int i = 0; i < 60; i++) exp_tx.push_back({i == 0, i == 59, gen_byte(i)});
  endtask

  task automatic send_tx(input int len, input int req_at);
    for (int i = 0; i < len; i++) exp_tx.push_back({i == 0, i == len - 1, 8'(8'h40 + i)});
    if (req_at >= 0) push_gen();
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      host_tx_valid = 1'b1; host_tx_sof = (i == 0); host_tx_eof = (i == len - 1);
      host_tx_data = 8'(8'h40 + i);
      pause_req = (i == req_at);
    end
    @(posedge clk); #1;
    host_tx_valid = 1'b0; host_tx_sof = 1'b0; host_tx_eof = 1'b0; pause_req = 1'b0;
  endtask

  // called right after send_rx returns: first edge is the load edge
  task automatic hold_window(input int q, input string tag);
    @(posedge clk);
    repeat ((q - 1) * S) @(posedge clk);
    #3 check(tx_inhibit == 1'b1, tag, 32'(tx_inhibit), 1);
    repeat (S) @(posedge clk);
    #3 check(tx_inhibit == 1'b0, tag, 32'(tx_inhibit), 0);
  endtask

  task automatic no_load(input string tag);
    @(posedge clk); #3 check(tx_inhibit == 1'b0, tag, 32'(tx_inhibit), 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && host_rx_valid) begin
      if (exp_rx.size() == 0) check(1'b0, "R2 R3 unexpected rx byte", 32'(host_rx_data), 0);
      else begin
        logic [10:0] e;
        e = exp_rx.pop_front();
        check({host_rx_sof, host_rx_eof, host_rx_drop, host_rx_data} == e, "R2 R3 rx item",
              32'({host_rx_sof, host_rx_eof, host_rx_drop, host_rx_data}), 32'(e));
      end
    end
    if (rst_n && tx_valid) begin
      if (exp_tx.size() == 0) check(1'b0, "R8 R9 R10 unexpected tx byte", 32'(tx_data), 0);
      else begin
        logic [9:0] e;
        e = exp_tx.pop_front();
        check({tx_sof, tx_eof, tx_data} == e, "R8 R9 R10 tx item",
              32'({tx_sof, tx_eof, tx_data}), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 check(!tx_inhibit && !host_rx_valid && !tx_valid, "R1 in reset",
             32'({tx_inhibit, host_rx_valid, tx_valid}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #3 check(!tx_inhibit && !host_rx_valid && !tx_valid, "R1 after reset",
                             32'({tx_inhibit, host_rx_valid, tx_valid}), 0);

    // R2: ordinary frame forwarded, not marked, no hold
    send_rx(STA, 16'h0800, 16'h0001, 16'h0005, 24, 1'b0);
    no_load("R2 ordinary frame no hold");

    // R3 R4 R5: group-address PAUSE, discard mode
    cfg_pass_ctrl = 1'b0;
    send_rx(GRP, 16'h8808, 16'h0001, 16'd3, 22, 1'b1);
    hold_window(3, "R5 hold window q3");

    // R3 R4: station-address PAUSE, pass mode
    cfg_pass_ctrl = 1'b1;
    send_rx(STA, 16'h8808, 16'h0001, 16'd2, 20, 1'b0);
    hold_window(2, "R4 pass mode still loads");

    // R4: other opcode marks but does not load
    cfg_pass_ctrl = 1'b0;
    send_rx(GRP, 16'h8808, 16'h0002, 16'd9, 20, 1'b1);
    no_load("R4 other opcode no hold");

    // R3: too short, foreign address
    send_rx(GRP, 16'h8808, 16'h0001, 16'd9, 17, 1'b0);
    no_load("R3 short frame no hold");
    send_rx(48'h02_99_88_77_66_55, 16'h8808, 16'h0001, 16'd9, 20, 1'b0);
    no_load("R3 foreign address no hold");

    // R7: reload during hold
    send_rx(GRP, 16'h8808, 16'h0001, 16'd5, 20, 1'b1);
    send_rx(GRP, 16'h8808, 16'h0001, 16'd2, 20, 1'b1);
    hold_window(2, "R7 reload restarts");

    // R6: zero clears
    send_rx(GRP, 16'h8808, 16'h0001, 16'd20, 20, 1'b1);
    send_rx(GRP, 16'h8808, 16'h0001, 16'd0, 20, 1'b1);
    no_load("R6 zero quanta clears");

    // R8: generated frame with idle host
    push_gen();
    @(posedge clk); #1 pause_req = 1'b1;
    @(posedge clk); #1 pause_req = 1'b0;
    #3 check(tx_inhibit == 1'b1, "R8 inhibit after request", 32'(tx_inhibit), 1);
    repeat (70) @(posedge clk);
    #3 check(tx_inhibit == 1'b0 && exp_tx.size() == 0, "R8 frame complete",
             32'(exp_tx.size()), 0);

    // R10: request inside open host frame
    send_tx(12, 4);
    repeat (70) @(posedge clk);
    #3 check(tx_inhibit == 1'b0 && exp_tx.size() == 0, "R10 inserted after host frame",
             32'(exp_tx.size()), 0);

    // R9: hold starts during a host frame, frame continues
    cfg_pass_ctrl = 1'b1;
    fork
      send_rx(GRP, 16'h8808, 16'h0001, 16'd3, 20, 1'b0);
      send_tx(30, -1);
    join
    #3 check(tx_inhibit == 1'b1 && exp_tx.size() == 0, "R9 open frame finished under hold",
             32'({tx_inhibit, 8'(exp_tx.size())}), 32'h100);
    repeat (4 * S) @(posedge clk);
    #3 check(tx_inhibit == 1'b0, "R9 hold released", 32'(tx_inhibit), 0);

    repeat (4) @(posedge clk);
    #3 check(exp_rx.size() == 0, "R2 all rx items seen", 32'(exp_rx.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule